// File: doc/BRIEF.md
# Serial Transmitter with Line Control

This block is the transmit half of an asynchronous serial port. Software reaches it through a byte-wide register interface: a line-control byte, a 16-bit bit-rate divisor, a transmit holding byte and an interrupt-enable byte. A byte written to the holding register moves into a frame shifter at the next bit-rate tick. The shifter then sends it on one serial line as a start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and one or two stop bits. Two status outputs report whether the holding register is free and whether the whole transmitter is empty.

The divisor bytes share addresses with the holding and interrupt-enable bytes. A bank-select bit in the line-control byte chooses which pair the two lowest addresses reach. Two diagnostic features are present. Stick parity sends the parity bit at a fixed level. Break holds the line low while the shifter keeps running underneath.

Top module: `uart_tx_lcr`

## Requirements
- R1: After reset, `txd` is 1, `thre` is 1 and `temt` is 1, and the line-control, divisor and interrupt-enable bytes all read 0.
- R2: Address 3 is the line-control byte, whose bit 7 is the bank select. When bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 the divisor high byte. When bit 7 is 0, a write to address 0 loads the holding register, address 0 reads 0, and address 1 reads and writes the interrupt-enable byte. Writes made in one bank leave the other bank's bytes unchanged.
- R3: With a non-zero divisor D, a rate tick occurs once every D clock cycles, and every bit on the line lasts 16 ticks (16·D clocks). When D is 0, no ticks occur and nothing is transmitted.
- R4: A frame starts with one low start bit, followed by the data bits, least significant bit first. Line-control bits [1:0] select the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R5: Line-control bit 2 selects one high stop bit when it is 0 and two high stop bits when it is 1.
- R6: When line-control bit 3 is 1, one parity bit is sent between the last data bit and the first stop bit. When bit 3 is 0, no parity bit is sent.
- R7: Line-control bit 4 selects the parity sense. With 1, the data bits plus the parity bit hold an even count of ones (even parity). With 0, they hold an odd count (odd parity).
- R8: When line-control bits 3 and 5 are both 1 (stick parity), the parity bit is the inverse of line-control bit 4, whatever the data.
- R9: While line-control bit 6 is 1, `txd` is 0. The shifter keeps its timing underneath, so when bit 6 is cleared part-way through a frame, the remaining bits come out at their normal times and levels.
- R10: A write to the holding register clears `thre` on the next cycle. `thre` returns to 1 when the byte moves into the shifter. `temt` is 1 only when the holding register and the shifter are both empty.
- R11: When no frame is being shifted and break is off, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| txd | output | 1 | Serial output line |
| thre | output | 1 | Holding register empty |
| temt | output | 1 | Holding register and shifter both empty |

## Verification
Most internal faults show up on `txd` within one frame. A bad bit counter or a bad frame builder moves or flips a bit, and a sample at mid-bit catches this inside 16 ticks. A bad tick counter stretches the start bit and shows in the first bit period. A fault in the holding-register flag or the busy flag shows on `thre` or `temt` one cycle after the write, or at the end of the frame. A banking fault shows at once on `rdata`, or later as a divisor change that alters the bit period.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    // Line-control byte: bit positions are software visible
    typedef struct packed {
        logic       bank;     // 7: divisor bank select
        logic       brk;      // 6: force line low
        logic       stick;    // 5: fixed parity level
        logic       even;     // 4: parity sense
        logic       par_en;   // 3: parity enable
        logic       two_stop; // 2: stop bit count
        logic [1:0] wlen;     // 1:0 data length minus 5
    } lcr_t;

    localparam logic [2:0] ADDR_LO  = 3'd0;
    localparam logic [2:0] ADDR_HI  = 3'd1;
    localparam logic [2:0] ADDR_LCR = 3'd3;
    localparam int         FRAME_W  = 12;
endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output lcr_t             lcr,
    output logic [DIV_W-1:0] divisor,
    output logic             thr_wr
);
    typedef struct packed {
        lcr_t       lcr;
        logic [7:0] dlo;
        logic [7:0] dhi;
        logic [7:0] ier;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        thr_wr = 1'b0;
        if (wr_en) begin
            unique case (addr)
                ADDR_LO:  if (r_q.lcr.bank) r_d.dlo = wdata; else thr_wr = 1'b1;
                ADDR_HI:  if (r_q.lcr.bank) r_d.dhi = wdata; else r_d.ier = wdata;
                ADDR_LCR: r_d.lcr = lcr_t'(wdata);
                default:  ;
            endcase
        end
        unique case (addr)
            ADDR_LO:  rdata = r_q.lcr.bank ? r_q.dlo : 8'h00;
            ADDR_HI:  rdata = r_q.lcr.bank ? r_q.dhi : r_q.ier;
            ADDR_LCR: rdata = r_q.lcr;
            default:  rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lcr     = r_q.lcr;
    assign divisor = DIV_W'({r_q.dhi, r_q.dlo});

    // R2
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_LO && !r_q.lcr.bank) |=> $stable(r_q.dlo));
endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = 1'b0;
        cnt_d = cnt_q + 1'b1;
        if (divisor == '0) begin
            cnt_d = '0;
        end else if (cnt_q >= divisor - 1'b1) begin
            tick  = 1'b1;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       thr_wr,
    input  logic [7:0] wdata,
    input  lcr_t       lcr,
    output logic       line,
    output logic       thre,
    output logic       temt
);
    localparam int SUB_W = $clog2(OVS);

    typedef struct packed {
        logic [7:0]         thr;
        logic               full;
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [3:0]         left;
        logic [SUB_W-1:0]   sub;
    } sh_t;

    sh_t s_d, s_q;
    logic [FRAME_W-1:0] frame;
    logic [3:0]         frame_len;
    logic [7:0]         dmask;
    logic               pbit;
    logic               load;

    always_comb begin
        dmask = '0;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < 5 + int'(lcr.wlen)) begin
                dmask[i]    = s_q.thr[i];
                frame[i+1]  = s_q.thr[i];
            end
        end
        pbit = lcr.stick ? ~lcr.even : (lcr.even ? ^dmask : ~^dmask);
        if (lcr.par_en) begin
            for (int p = 6; p <= 9; p++) begin
                if (p == 6 + int'(lcr.wlen)) frame[p] = pbit;
            end
        end
        frame_len = 4'd7 + {2'b00, lcr.wlen} + {3'b000, lcr.par_en} + {3'b000, lcr.two_stop};
    end

    always_comb begin
        s_d  = s_q;
        load = tick && !s_q.busy && s_q.full;
        if (s_q.busy && tick) begin
            if (s_q.sub == SUB_W'(OVS - 1)) begin
                s_d.sub  = '0;
                s_d.sh   = {1'b1, s_q.sh[FRAME_W-1:1]};
                s_d.left = s_q.left - 1'b1;
                if (s_q.left == 4'd1) s_d.busy = 1'b0;
            end else begin
                s_d.sub = s_q.sub + 1'b1;
            end
        end
        if (load) begin
            s_d.sh   = frame;
            s_d.left = frame_len;
            s_d.busy = 1'b1;
            s_d.sub  = '0;
            s_d.full = 1'b0;
        end
        if (thr_wr) begin
            s_d.thr  = wdata;
            s_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign line = s_q.busy ? s_q.sh[0] : 1'b1;
    assign thre = !s_q.full;
    assign temt = !s_q.full && !s_q.busy;

    // R10
    thr_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !thre);
    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(s_q.sub) && $stable(s_q.busy)));
endmodule

// File: rtl/uart_tx_lcr.sv
module uart_tx_lcr
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       txd,
    output logic       thre,
    output logic       temt
);
    lcr_t             lcr;
    logic [DIV_W-1:0] divisor;
    logic             thr_wr;
    logic             tick;
    logic             line;

    uart_tx_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lcr(lcr), .divisor(divisor), .thr_wr(thr_wr)
    );

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    uart_tx_shift #(.OVS(OVS)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .thr_wr(thr_wr), .wdata(wdata),
        .lcr(lcr), .line(line), .thre(thre), .temt(temt)
    );

    assign txd = lcr.brk ? 1'b0 : line;

    // R9
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcr.brk |-> !txd);
    // R11
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (temt && !lcr.brk) |-> txd);
    // R10
    temt_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temt |-> thre);
endmodule

// File: tb/uart_tx_lcr_test.sv
module uart_tx_lcr_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       txd, thre, temt;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    uart_tx_lcr uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .txd(txd), .thre(thre), .temt(temt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_div(input logic [15:0] dv, input logic [7:0] cfg);
        wr(3'd3, 8'h80 | cfg);
        wr(3'd0, dv[7:0]);
        wr(3'd1, dv[15:8]);
        wr(3'd3, cfg);
    endtask

    // Expected frame built from R4..R8
    function automatic int build(input logic [7:0] cfg, input logic [7:0] d,
                                 output logic [11:0] bits);
        int w = 5 + int'(cfg[1:0]);
        int n = 0;
        logic par = 1'b0;
        bits = '1;
        bits[n++] = 1'b0;
        for (int i = 0; i < w; i++) begin
            bits[n++] = d[i];
            par ^= d[i];
        end
        if (cfg[3]) begin
            if (cfg[5])      bits[n++] = ~cfg[4];
            else if (cfg[4]) bits[n++] = par;
            else             bits[n++] = ~par;
        end
        n += cfg[2] ? 2 : 1;
        return n;
    endfunction

    task automatic wait_fall(input string req);
        int t = 0;
        while (txd !== 1'b0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 4000) check({req, " start bit seen"}, 0, 1);
    endtask

    // Observe one frame at divisor 1 and compare every bit at mid-bit
    task automatic expect_frame(input logic [7:0] cfg, input logic [7:0] d, input string req);
        logic [11:0] bits;
        int n = build(cfg, d, bits);
        wait_fall(req);
        repeat (8) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            check($sformatf("%s bit%0d", req, b), int'(txd), int'(bits[b]));
            if (b < n - 1) repeat (16) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check({req, " R10 temt after frame"}, int'(temt), 1);
        check({req, " R11 idle high"}, int'(txd), 1);
    endtask

    task automatic send(input logic [7:0] cfg, input logic [7:0] d, input string req);
        wr(3'd3, cfg);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd0; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        check({req, " R10 thre low after write"}, int'(thre), 0);
        check({req, " R10 temt low after write"}, int'(temt), 0);
        expect_frame(cfg, d, req);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 txd", int'(txd), 1);
        check("R1 thre", int'(thre), 1);
        check("R1 temt", int'(temt), 1);
        rd(3'd3, v); check("R1 lcr", int'(v), 0);
        rd(3'd1, v); check("R1 ier", int'(v), 0);
        wr(3'd3, 8'h80);
        rd(3'd0, v); check("R1 div lo", int'(v), 0);
        rd(3'd1, v); check("R1 div hi", int'(v), 0);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_bank();
        logic [7:0] v;
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd(3'd0, v); check("R2 div lo", int'(v), 8'h34);
        rd(3'd1, v); check("R2 div hi", int'(v), 8'h12);
        wr(3'd3, 8'h03);
        wr(3'd1, 8'h05);
        rd(3'd1, v); check("R2 ier", int'(v), 8'h05);
        rd(3'd0, v); check("R2 data reads zero", int'(v), 0);
        wr(3'd3, 8'h83);
        rd(3'd1, v); check("R2 div hi kept", int'(v), 8'h12);
        wr(3'd3, 8'h03);
    endtask

    task automatic t_div_zero();
        set_div(16'd0, 8'h03);
        wr(3'd0, 8'h5A);
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1) break;
        end
        check("R3 div 0 no frame", int'(txd), 1);
        check("R3 div 0 thre held", int'(thre), 0);
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h01);
        wr(3'd3, 8'h03);
        expect_frame(8'h03, 8'h5A, "R3 restart");
    endtask

    task automatic t_rate();
        int low = 0;
        set_div(16'd3, 8'h03);
        wr(3'd0, 8'h01);
        wait_fall("R3 rate");
        while (txd === 1'b0 && low < 1000) begin
            low++;
            @(negedge clk);
        end
        check("R3 start bit 48 clocks at divisor 3", low, 48);
        repeat (600) @(negedge clk);
        check("R3 done", int'(temt), 1);
        set_div(16'd1, 8'h03);
    endtask

    task automatic t_break_idle();
        wr(3'd3, 8'h43);
        @(negedge clk);
        check("R9 break idle low", int'(txd), 0);
        wr(3'd3, 8'h03);
        check("R9 break clear high", int'(txd), 1);
    endtask

    task automatic t_break_mid();
        wr(3'd3, 8'h03);
        wr(3'd0, 8'hFF);
        wait_fall("R9 mid");
        repeat (8) @(negedge clk);
        check("R9 start", int'(txd), 0);
        repeat (16) @(negedge clk);
        wr_en = 1'b1; addr = 3'd3; wdata = 8'h43;
        @(negedge clk); wr_en = 1'b0;
        repeat (15) @(negedge clk);
        check("R9 break overrides bit2", int'(txd), 0);
        wr_en = 1'b1; addr = 3'd3; wdata = 8'h03;
        @(negedge clk); wr_en = 1'b0;
        repeat (15) @(negedge clk);
        check("R9 bit3 restored", int'(txd), 1);
        for (int b = 4; b <= 9; b++) begin
            repeat (16) @(negedge clk);
            check($sformatf("R9 bit%0d", b), int'(txd), 1);
        end
        repeat (10) @(negedge clk);
        check("R9 temt", int'(temt), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank();
        set_div(16'd1, 8'h03);
        send(8'h03, 8'hA5, "R4 8N1");
        send(8'h00, 8'h16, "R4 5N1");
        send(8'h1A, 8'h53, "R7 7E1");
        send(8'h0D, 8'h2C, "R6 R5 6O2");
        send(8'h0B, 8'h01, "R6 8O1");
        send(8'h3B, 8'h01, "R8 stick even");
        send(8'h2B, 8'h01, "R8 stick odd");
        send(8'h07, 8'h81, "R5 8N2");
        t_break_idle();
        t_break_mid();
        t_div_zero();
        t_rate();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule